// File: doc/BRIEF.md
# CD-ROM Sector Aligner and Descrambler

This block takes a raw CD-ROM byte stream made of 2352-byte sectors. It finds the 12-byte sync field and locks to the sector grid. A flywheel then holds that grid, filling in any sync that is missing. The block strips the sync field and descrambles the remaining 2340 bytes of each sector. It classifies each sector by its header and reports, once per sector, the mode, the form and whether it is a link sector.

Bytes arrive with a valid strobe and idle cycles may occur anywhere. Each accepted payload byte leaves one cycle later, descrambled. The first payload byte of a sector carries a start marker. The last payload byte carries a status strobe, and the sector classification is valid on that same cycle. Error correction and checksum checking are done by the downstream logic.

Top module: `cd_sector_aligner`

## Requirements
- R1: While rst_n is low at a clock edge, every output is driven to 0 on that edge, and the block comes out of reset unlocked.
- R2: When unlocked, the block emits no bytes. It locks as soon as 12 consecutive accepted bytes read 0x00, then ten 0xFF, then 0x00. The next accepted byte is then sector byte 12.
- R3: When locked, sector bytes 12 to 2351 are each presented on out_byte with out_valid high, one cycle after they are accepted, and out_sos is high on byte 12. A cycle with in_valid low neither advances the position nor emits a byte.
- R4: Each emitted byte is the input byte XORed with a keystream from a 15-bit LFSR (x^15+x+1). The LFSR is loaded with 0x0001 for byte 12. Keystream bits are taken LSB first: each bit is state[0], and the state then shifts right with state[0]^state[1] entering bit 14.
- R5: stat_valid is high together with the output of byte 2351. With it, sec_mode gives the descrambled byte 15: values 0, 1 and 2 appear as is, and any larger value appears as 3.
- R6: When the mode byte is 2, sec_form equals bit 5 of descrambled byte 18 (0 = form 1, 1 = form 2). For any other mode it is 0.
- R7: sec_link is 1 only when the mode byte is 0 and all descrambled bytes 16 to 2351 are 0x00.
- R8: When locked, if bytes 0 to 11 of a sector do not hold the sync pattern, the block keeps the sector grid and still emits the sector. It reports sec_ins = 1 in that sector's status. A sector with a correct sync reports 0.
- R9: On the third consecutive sector whose sync is missing, the block unlocks instead and emits nothing for that sector. Search resumes with the next byte. A correct sync clears the miss count.
- R10: When locked, a sync pattern at any other position in the sector is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | in_byte holds a stream byte |
| in_byte | input | 8 | Raw sector byte |
| out_valid | output | 1 | out_byte holds a descrambled payload byte |
| out_byte | output | 8 | Descrambled byte (sector bytes 12..2351) |
| out_sos | output | 1 | First payload byte of a sector |
| locked | output | 1 | Block is aligned to the sector grid |
| stat_valid | output | 1 | Last payload byte; sector status valid |
| sec_mode | output | 2 | Sector mode code (3 = other) |
| sec_form | output | 1 | Form of a mode-2 sector |
| sec_link | output | 1 | Link sector detected |
| sec_ins | output | 1 | This sector's sync was inserted |

## Verification
The hardest state to reach is the miss counter at its limit. That takes two sectors in a row with a damaged sync, and then a choice between a third damaged sector, which must drop lock, and a good one, which must clear the counter. The stimulus builds whole sectors with a selectable corruption of the sync field. It runs corrupt, corrupt, good, and then corrupt three times. After that it sends garbage and a clean sector to show that the block locks again. A sync pattern planted in the middle of a payload tests the flywheel, and idle cycles are inserted into the first sector.

// File: rtl/cdsa_pkg.sv
// Shared constants and helper functions for the CD-ROM sector aligner.
// Assumes a raw sector of SECTOR_LEN bytes beginning with a SYNC_LEN-byte sync field.
package cdsa_pkg;
    localparam int SECTOR_LEN = 2352;
    localparam int SYNC_LEN   = 12;
    localparam int MODE_POS   = 15;
    localparam int SUBHDR_POS = 18;
    localparam int FORM_BIT   = 5;
    localparam int DATA_START = 16;
    localparam int POS_W      = $clog2(SECTOR_LEN);
    localparam int LFSR_W     = 15;
    localparam logic [LFSR_W-1:0] LFSR_SEED = 15'h0001;

    typedef logic [POS_W-1:0] pos_t;

    // Expected value of sync byte k (0 = first byte of the field).
    function automatic logic [7:0] sync_byte(input int k);
        return (k == 0 || k == SYNC_LEN - 1) ? 8'h00 : 8'hFF;
    endfunction

    // One byte of keystream, LSB first, from LFSR state s.
    function automatic logic [7:0] lfsr_byte(input logic [LFSR_W-1:0] s);
        logic [LFSR_W-1:0] r;
        logic [7:0] b;
        r = s;
        for (int i = 0; i < 8; i++) begin
            b[i] = r[0];
            r = {r[0] ^ r[1], r[LFSR_W-1:1]};
        end
        return b;
    endfunction

    // LFSR state after eight shifts.
    function automatic logic [LFSR_W-1:0] lfsr_step8(input logic [LFSR_W-1:0] s);
        logic [LFSR_W-1:0] r;
        r = s;
        for (int i = 0; i < 8; i++) r = {r[0] ^ r[1], r[LFSR_W-1:1]};
        return r;
    endfunction
endpackage

// File: rtl/cdsa_sync_window.sv
// Sliding window over the last SYNC_LEN accepted bytes. It flags a match when the
// current byte completes the sync pattern. Assumes in_byte is only meaningful when in_valid is high.
module cdsa_sync_window
    import cdsa_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic [7:0] in_byte,
    output logic       match
);
    localparam int HIST_BYTES = SYNC_LEN - 1;

    logic [HIST_BYTES*8-1:0] hist;   // newest byte in the low bits
    logic [HIST_BYTES-1:0]   ok;

    // Shift each accepted byte into the history.
    always_ff @(posedge clk) begin
        if (!rst_n) hist <= '0;
        else if (in_valid) hist <= {hist[HIST_BYTES*8-9:0], in_byte};
    end

    // Compare each stored byte against its place in the pattern.
    genvar k;
    generate
        for (k = 0; k < HIST_BYTES; k++) begin : g_cmp
            assign ok[k] = (hist[8*(HIST_BYTES-k)-1 -: 8] == sync_byte(k));
        end
    endgenerate

    // Match when the history and the current byte complete the pattern.
    always_comb match = in_valid && (&ok) && (in_byte == sync_byte(SYNC_LEN - 1));
endmodule

// File: rtl/cdsa_tracker.sv
// Lock state machine and byte position counter with flywheel sync insertion.
// Assumes match comes from cdsa_sync_window for the same byte.
module cdsa_tracker
    import cdsa_pkg::*;
#(
    parameter int MISS_LIMIT = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic match,
    output logic locked,
    output pos_t pos,
    output logic emit,
    output logic seed,
    output logic last,
    output logic ins
);
    localparam int   MISS_W     = $clog2(MISS_LIMIT + 1);
    localparam pos_t P_SYNC_END = pos_t'(SYNC_LEN - 1);
    localparam pos_t P_FIRST    = pos_t'(SYNC_LEN);
    localparam pos_t P_LAST     = pos_t'(SECTOR_LEN - 1);

    logic [MISS_W-1:0] miss;

    // Decode the position of the current byte into payload strobes.
    always_comb begin
        emit = in_valid && locked && (pos >= P_FIRST);
        seed = emit && (pos == P_FIRST);
        last = emit && (pos == P_LAST);
    end

    // Search, lock, flywheel insertion and loss of lock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            locked <= 1'b0;
            pos    <= '0;
            miss   <= '0;
            ins    <= 1'b0;
        end else if (in_valid) begin
            if (!locked) begin
                if (match) begin
                    locked <= 1'b1;
                    pos    <= P_FIRST;
                    miss   <= '0;
                    ins    <= 1'b0;
                end
            end else if (pos == P_SYNC_END) begin
                if (match) begin
                    miss <= '0;
                    ins  <= 1'b0;
                    pos  <= P_FIRST;
                end else if (miss == MISS_W'(MISS_LIMIT - 1)) begin
                    locked <= 1'b0;
                    miss   <= '0;
                    pos    <= '0;
                end else begin
                    miss <= miss + 1'b1;
                    ins  <= 1'b1;
                    pos  <= P_FIRST;
                end
            end else if (pos == P_LAST) begin
                pos <= '0;
            end else begin
                pos <= pos + 1'b1;
            end
        end
    end

    AST_POS_RANGE: assert property (@(posedge clk) disable iff (!rst_n) pos <= P_LAST); // R3
    AST_MISS_BOUND: assert property (@(posedge clk) disable iff (!rst_n) miss < MISS_W'(MISS_LIMIT)); // R9
    AST_INS_ON_GRID: assert property (@(posedge clk) disable iff (!rst_n) $rose(ins) |-> (pos == P_FIRST && locked)); // R8
endmodule

// File: rtl/cdsa_descrambler.sv
// Keystream generator for the payload bytes. It reloads the seed on the first payload
// byte and advances one byte per emitted byte. Assumes seed is only high when step is high.
module cdsa_descrambler
    import cdsa_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       step,
    input  logic       seed,
    output logic [7:0] ks
);
    logic [LFSR_W-1:0] state;
    logic [LFSR_W-1:0] base;

    // Use the seed for the first byte, otherwise the running state.
    always_comb begin
        base = seed ? LFSR_SEED : state;
        ks   = lfsr_byte(base);
    end

    // Advance the LFSR by one byte per payload byte.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= LFSR_SEED;
        else if (step) state <= lfsr_step8(base);
    end

    AST_LFSR_LIVE: assert property (@(posedge clk) disable iff (!rst_n) state != '0); // R4
endmodule

// File: rtl/cdsa_header_sniffer.sv
// Captures the mode byte and subheader form bit and tracks an all-zero data area.
// It gives the sector classification on the last payload byte. Assumes db is already descrambled.
module cdsa_header_sniffer
    import cdsa_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       emit,
    input  pos_t       pos,
    input  logic [7:0] db,
    output logic [1:0] mode_code,
    output logic       form,
    output logic       link
);
    logic [7:0] mode_q;
    logic       form_q;
    logic       zero_q;

    // Record header fields and the running all-zero flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
            form_q <= 1'b0;
            zero_q <= 1'b0;
        end else if (emit) begin
            if (pos == pos_t'(MODE_POS))   mode_q <= db;
            if (pos == pos_t'(SUBHDR_POS)) form_q <= db[FORM_BIT];
            if (pos == pos_t'(DATA_START)) zero_q <= (db == 8'h00);
            else if (pos > pos_t'(DATA_START)) zero_q <= zero_q && (db == 8'h00);
        end
    end

    // Classification, including the current (last) data byte.
    always_comb begin
        mode_code = (mode_q > 8'd2) ? 2'd3 : mode_q[1:0];
        form      = (mode_q == 8'd2) && form_q;
        link      = (mode_q == 8'd0) && zero_q && (db == 8'h00);
    end
endmodule

// File: rtl/cd_sector_aligner.sv
// Top level: sync search with flywheel, payload descrambling, and per-sector classification.
// Every output is registered, and a payload byte appears one cycle after it is accepted.
module cd_sector_aligner
    import cdsa_pkg::*;
#(
    parameter int MISS_LIMIT = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic [7:0] in_byte,
    output logic       out_valid,
    output logic [7:0] out_byte,
    output logic       out_sos,
    output logic       locked,
    output logic       stat_valid,
    output logic [1:0] sec_mode,
    output logic       sec_form,
    output logic       sec_link,
    output logic       sec_ins
);
    logic       match, emit, seed, last, ins;
    pos_t       pos;
    logic [7:0] ks, db;
    logic [1:0] mode_code;
    logic       form, link;

    cdsa_sync_window u_win (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte), .match(match)
    );

    cdsa_tracker #(.MISS_LIMIT(MISS_LIMIT)) u_trk (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .match(match),
        .locked(locked), .pos(pos), .emit(emit), .seed(seed), .last(last), .ins(ins)
    );

    cdsa_descrambler u_dsc (
        .clk(clk), .rst_n(rst_n), .step(emit), .seed(seed), .ks(ks)
    );

    always_comb db = in_byte ^ ks;

    cdsa_header_sniffer u_hdr (
        .clk(clk), .rst_n(rst_n), .emit(emit), .pos(pos), .db(db),
        .mode_code(mode_code), .form(form), .link(link)
    );

    // Register the payload stream and the per-sector status.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_byte   <= '0;
            out_sos    <= 1'b0;
            stat_valid <= 1'b0;
            sec_mode   <= '0;
            sec_form   <= 1'b0;
            sec_link   <= 1'b0;
            sec_ins    <= 1'b0;
        end else begin
            out_valid  <= emit;
            out_byte   <= emit ? db : 8'h00;
            out_sos    <= seed;
            stat_valid <= last;
            if (last) begin
                sec_mode <= mode_code;
                sec_form <= form;
                sec_link <= link;
                sec_ins  <= ins;
            end
        end
    end

    AST_SOS_IS_DATA: assert property (@(posedge clk) disable iff (!rst_n) out_sos |-> out_valid); // R3
    AST_NO_DATA_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n) out_valid |-> locked); // R2
    AST_STAT_IS_DATA: assert property (@(posedge clk) disable iff (!rst_n) stat_valid |-> (out_valid && !out_sos)); // R5
    AST_FORM_NEEDS_MODE2: assert property (@(posedge clk) disable iff (!rst_n) (stat_valid && sec_form) |-> sec_mode == 2'd2); // R6
    AST_LINK_NEEDS_MODE0: assert property (@(posedge clk) disable iff (!rst_n) (stat_valid && sec_link) |-> sec_mode == 2'd0); // R7
endmodule

// File: tb/test_cd_sector_aligner.sv
// Behavioural reference model compared with the design on every clock.
module test_cd_sector_aligner;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_byte = 8'h00;
    logic       out_valid, out_sos, locked, stat_valid, sec_form, sec_link, sec_ins;
    logic [7:0] out_byte;
    logic [1:0] sec_mode;

    always #10 clk = ~clk;   // 50 MHz

    cd_sector_aligner i_cd_sector_aligner (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
        .out_valid(out_valid), .out_byte(out_byte), .out_sos(out_sos), .locked(locked),
        .stat_valid(stat_valid), .sec_mode(sec_mode), .sec_form(sec_form),
        .sec_link(sec_link), .sec_ins(sec_ins)
    );

    int vectors = 0;
    int miscompares = 0;
    bit done = 0;
    string scen = "R1";

    // Keystream for payload bytes 12..2351.
    int ks [2340];
    // Raw sector under construction.
    int raw [2352];
    int seedv = 12345;

    // Model state.
    int hist [$];
    bit m_lock = 0;
    int m_pos = 0, m_miss = 0;
    bit m_ins = 0;
    int m_mode = 0, m_form = 0;
    bit m_zero = 0;
    // Expected outputs for the next sample.
    bit e_v = 0, e_sos = 0, e_stat = 0, e_link = 0, e_ins = 0;
    int e_byte = 0, e_mode = 0, e_form = 0;

    function automatic int rnd();
        seedv = (seedv * 1103515245 + 12345) & 32'h7fffffff;
        return (seedv >> 16) & 8'hff;
    endfunction

    task automatic chk(input string tag, input string what, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %0d expected %0d (scenario %s)", tag, what, act, exp, scen);
        end
    endtask

    task automatic compare_all();
        chk("R3", "out_valid", int'(out_valid), int'(e_v));
        chk("R3", "out_sos", int'(out_sos), int'(e_sos));
        chk("R2", "locked", int'(locked), int'(m_lock));
        chk("R5", "stat_valid", int'(stat_valid), int'(e_stat));
        if (e_v) chk("R4", "out_byte", int'(out_byte), e_byte);
        if (e_stat) begin
            chk("R5", "sec_mode", int'(sec_mode), e_mode);
            chk("R6", "sec_form", int'(sec_form), e_form);
            chk("R7", "sec_link", int'(sec_link), int'(e_link));
            chk("R8", "sec_ins", int'(sec_ins), int'(e_ins));
        end
    endtask

    // Advance the reference model by one cycle's input.
    task automatic model(input bit v, input int b);
        bit match;
        int db;
        e_v = 0; e_sos = 0; e_stat = 0;
        if (!v) return;
        hist.push_back(b);
        if (hist.size() > 12) void'(hist.pop_front());
        match = (hist.size() == 12);
        for (int k = 0; k < hist.size(); k++)
            if (hist[k] != ((k == 0 || k == 11) ? 0 : 255)) match = 0;
        if (!m_lock) begin
            if (match) begin m_lock = 1; m_pos = 12; m_miss = 0; m_ins = 0; end
        end else if (m_pos == 11) begin
            if (match) begin m_miss = 0; m_ins = 0; m_pos = 12; end
            else if (m_miss == 2) begin m_lock = 0; m_miss = 0; m_pos = 0; end
            else begin m_miss++; m_ins = 1; m_pos = 12; end
        end else if (m_pos >= 12) begin
            db = b ^ ks[m_pos - 12];
            e_v = 1; e_byte = db; e_sos = (m_pos == 12);
            if (m_pos == 15) m_mode = db;
            if (m_pos == 18) m_form = (db >> 5) & 1;
            if (m_pos == 16) m_zero = (db == 0);
            else if (m_pos > 16) m_zero = m_zero && (db == 0);
            if (m_pos == 2351) begin
                e_stat = 1;
                e_mode = (m_mode > 2) ? 3 : m_mode;
                e_form = (m_mode == 2) ? m_form : 0;
                e_link = (m_mode == 0) && m_zero;
                e_ins  = m_ins;
                m_pos = 0;
            end else m_pos++;
        end else m_pos++;
    endtask

    task automatic step(input bit v, input int b);
        @(negedge clk);
        compare_all();
        in_valid = v;
        in_byte = 8'(b);
        model(v, b);
    endtask

    // Build and send one sector. kind: 0 random data, 1 all-zero data, 2 zero with one stray byte.
    task automatic send_sector(input int mode, input int sub18, input int kind,
                               input bit bad_sync, input bit spurious, input bit gaps);
        int pl;
        for (int i = 0; i < 12; i++) raw[i] = (i == 0 || i == 11) ? 0 : 255;
        if (bad_sync) raw[5] = 8'h7E;
        for (int i = 12; i < 2352; i++) begin
            if (i == 15) pl = mode;
            else if (i == 18) pl = sub18;
            else if (i < 16) pl = rnd();
            else if (kind == 1) pl = 0;
            else if (kind == 2) pl = (i == 2000) ? 1 : 0;
            else pl = rnd();
            raw[i] = pl ^ ks[i - 12];
        end
        if (spurious)
            for (int i = 500; i < 512; i++) raw[i] = (i == 500 || i == 511) ? 0 : 255;
        for (int i = 0; i < 2352; i++) begin
            if (gaps && (i % 97) == 0) step(0, 0);
            step(1, raw[i]);
        end
    endtask

    task automatic garbage(input int n);
        for (int i = 0; i < n; i++) step(1, rnd() & 8'h7f);
    endtask

    initial begin
        int st, bv, fb;
        st = 1;
        for (int j = 0; j < 2340; j++) begin
            bv = 0;
            for (int i = 0; i < 8; i++) begin
                bv = bv | ((st & 1) << i);
                fb = (st ^ (st >> 1)) & 1;
                st = (st >> 1) | (fb << 14);
            end
            ks[j] = bv;
        end
        // R1: outputs during reset
        repeat (4) begin
            @(negedge clk);
            chk("R1", "out_valid", int'(out_valid), 0);
            chk("R1", "locked", int'(locked), 0);
            chk("R1", "stat/sos", int'(stat_valid | out_sos | sec_link | sec_ins | sec_form), 0);
            chk("R1", "out_byte", int'(out_byte), 0);
            chk("R1", "sec_mode", int'(sec_mode), 0);
        end
        rst_n = 1'b1;
        scen = "R2"; garbage(50);
        scen = "R3"; send_sector(1, 0, 0, 0, 0, 1);
        scen = "R6"; send_sector(2, 8'h20, 0, 0, 0, 0);
        send_sector(2, 8'h00, 0, 0, 0, 0);
        scen = "R7"; send_sector(0, 0, 1, 0, 0, 0);
        send_sector(0, 0, 2, 0, 0, 0);
        scen = "R5"; send_sector(7, 0, 0, 0, 0, 0);
        scen = "R10"; send_sector(1, 0, 0, 0, 1, 0);
        scen = "R8"; send_sector(1, 0, 0, 1, 0, 0);
        send_sector(2, 8'h20, 0, 0, 0, 0);
        scen = "R9"; send_sector(1, 0, 0, 1, 0, 0);
        send_sector(1, 0, 0, 1, 0, 0);
        send_sector(1, 0, 0, 0, 0, 0);
        send_sector(1, 0, 0, 1, 0, 0);
        send_sector(1, 0, 0, 1, 0, 0);
        send_sector(1, 0, 0, 1, 0, 0);
        garbage(30);
        scen = "R2"; send_sector(2, 0, 0, 0, 0, 0);
        step(0, 0); step(0, 0);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule